// File: doc/BRIEF.md
# Prioritized Exception Arbiter

This block sits beside the sequencer of an 8-bit processor core. At every instruction boundary it decides whether an exception is entered and which one. It watches three request lines, the two inhibit bits of the condition codes, a strobe that marks a write of the system stack pointer, and two flags that say whether the core is parked in a wait-for-interrupt state. The wait may be a state-saving wait, with the frame already pushed, or a bare synchronisation wait.

For each check it gives one answer. It either enters an exception, holds the wait for one more cycle, or lets execution continue. When an exception is entered, it names the vector address, the frame kind (full or short), whether the stacking engine must still push that frame, which inhibit bits the core must set, and how many cycles the entry costs. A separate stacking engine and the sequencer act on these outputs.

The non-maskable request is caught on its rising edge. It is only accepted once the stack pointer has been loaded after reset. The two maskable requests are level-sensitive.

Top module: `exc_arbiter`

## Requirements
- R1: Outputs only change from their idle values when `chk` is high. When several sources are serviceable, the non-maskable request wins first, then the fast request, then the normal request.
- R2: A mask input of 1 inhibits its request. The fast and normal requests are level-sensitive: they are taken at a check whenever their line is high and their mask is 0.
- R3: A rising edge of `nmi_req` seen while armed leaves the non-maskable request pending. It stays pending across any number of cycles until it is taken. Each edge is taken exactly once.
- R4: The non-maskable source becomes armed at the first clock edge with `sp_wr` high after reset. Rising edges that occur before that are discarded. Reset disarms the source and drops any pending request.
- R5: While `take` is high, `vector` is 0xFFFC for the non-maskable source, 0xFFF6 for the fast source and 0xFFF8 for the normal source. At all other times, including during reset, it reads 0xFFFE.
- R6: Taking the non-maskable or the fast source raises both `set_firq_msk` and `set_irq_msk`. Taking the normal source raises only `set_irq_msk`.
- R7: `full_frame` is 1 for the non-maskable and normal sources and 0 for the fast source. `push_frame` is 1 on every take outside a state-saving wait.
- R8: `cost` reads 19 for a non-maskable or normal entry and 10 for a fast entry. It reads 0 when nothing is taken and nothing is held.
- R9: In a state-saving wait (`wait_cwai`), a check with no serviceable request gives `hold`=1 and `cost`=1. A serviceable request is taken with `push_frame`=0 and `wait_clr`=1.
- R10: In a synchronisation wait (`wait_sync`), a check with no line asserted and nothing pending gives `hold`=1 and `cost`=1. Any asserted line, masked or not, ends the wait with `wait_clr`=1. A serviceable request is also taken with `push_frame`=1. If only masked lines are asserted, `take`=0 and `cost`=0.
- R11: While `rst` is high, `take`=0 and `set_firq_msk`, `set_irq_msk` and `wait_clr` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk | input | 1 | Instruction-boundary check strobe |
| nmi_req | input | 1 | Non-maskable request line (edge-caught) |
| firq_req | input | 1 | Fast request line (level) |
| irq_req | input | 1 | Normal request line (level) |
| firq_mask | input | 1 | Fast inhibit bit, 1 = inhibited |
| irq_mask | input | 1 | Normal inhibit bit, 1 = inhibited |
| sp_wr | input | 1 | System stack pointer was written |
| wait_cwai | input | 1 | Core is in the state-saving wait |
| wait_sync | input | 1 | Core is in the synchronisation wait |
| take | output | 1 | Enter an exception this cycle |
| vector | output | 16 | Vector address to fetch |
| full_frame | output | 1 | 1 = full frame with entire flag set, 0 = short frame |
| push_frame | output | 1 | Stacking engine must push the frame |
| set_firq_msk | output | 1 | Set the fast inhibit bit |
| set_irq_msk | output | 1 | Set the normal inhibit bit |
| cost | output | 5 | Cycle cost of this check |
| hold | output | 1 | Remain in the wait state |
| wait_clr | output | 1 | Clear the wait flags |

## Verification
The bench targets edges that arrive before the stack pointer is loaded. A design that arms too early would take a spurious non-maskable entry. It also tests a non-maskable edge held for many cycles without a check, and a request line held high after service. A design that loses the latch would miss the entry, and one that treats the line as a level would retrigger. Masked requests are applied during both kinds of wait. This separates a synchronisation wait, which must be released, from a state-saving wait, which must keep holding. A design that mixed up the two would either hang or enter a masked exception. It also checks that only the state-saving wait suppresses the push.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_FIRQ = 2'd2,
        SRC_IRQ  = 2'd3
    } src_e;

    typedef struct packed {
        logic full;
        logic set_f;
        logic set_i;
    } entry_t;

    localparam logic [15:0] DEF_VEC_RESET = 16'hFFFE;
    localparam logic [15:0] DEF_VEC_NMI   = 16'hFFFC;
    localparam logic [15:0] DEF_VEC_IRQ   = 16'hFFF8;
    localparam logic [15:0] DEF_VEC_FIRQ  = 16'hFFF6;

    function automatic entry_t entry_of(src_e s);
        entry_t e;
        e = '{full: 1'b0, set_f: 1'b0, set_i: 1'b0};
        case (s)
            SRC_NMI:  e = '{full: 1'b1, set_f: 1'b1, set_i: 1'b1};
            SRC_FIRQ: e = '{full: 1'b0, set_f: 1'b1, set_i: 1'b1};
            SRC_IRQ:  e = '{full: 1'b1, set_f: 1'b0, set_i: 1'b1};
            default:  e = '{full: 1'b0, set_f: 1'b0, set_i: 1'b0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/arb_nmi_latch.sv
module arb_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_line,
    input  logic sp_wr,
    input  logic serviced,
    output logic pending
);
    logic armed_q;
    logic prev_q;
    logic pend_q;
    logic edge_ok;

    assign edge_ok = armed_q & nmi_line & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            prev_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            armed_q <= armed_q | sp_wr;
            prev_q  <= nmi_line;
            pend_q  <= (pend_q & ~serviced) | edge_ok;
        end
    end

    assign pending = pend_q;

    // R4: nothing can become pending while disarmed
    p_disarmed_r4: assert property (@(posedge clk) disable iff (rst)
        !armed_q |=> !pend_q);

    // R3: a pending request survives until serviced
    p_hold_pend_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !serviced) |=> pend_q);

    // R3: servicing drains the request unless a fresh edge arrives
    p_drain_r3: assert property (@(posedge clk) disable iff (rst)
        (serviced && !(nmi_line && !prev_q)) |=> !pend_q);

endmodule

// File: rtl/arb_select.sv
module arb_select
    import irq_arb_pkg::*;
(
    input  logic nmi_pend,
    input  logic firq_req,
    input  logic irq_req,
    input  logic firq_mask,
    input  logic irq_mask,
    output src_e src,
    output logic any_line
);
    logic firq_ok;
    logic irq_ok;

    assign firq_ok  = firq_req & ~firq_mask;
    assign irq_ok   = irq_req & ~irq_mask;
    assign any_line = nmi_pend | firq_req | irq_req;

    always_comb begin
        if (nmi_pend)     src = SRC_NMI;
        else if (firq_ok) src = SRC_FIRQ;
        else if (irq_ok)  src = SRC_IRQ;
        else              src = SRC_NONE;
    end

endmodule

// File: rtl/arb_waitgate.sv
module arb_waitgate
    import irq_arb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int COST_W = 5,
    parameter logic [ADDR_W-1:0] VEC_RESET = DEF_VEC_RESET,
    parameter logic [ADDR_W-1:0] VEC_NMI   = DEF_VEC_NMI,
    parameter logic [ADDR_W-1:0] VEC_FIRQ  = DEF_VEC_FIRQ,
    parameter logic [ADDR_W-1:0] VEC_IRQ   = DEF_VEC_IRQ,
    parameter logic [COST_W-1:0] COST_FULL  = 19,
    parameter logic [COST_W-1:0] COST_SHORT = 10,
    parameter logic [COST_W-1:0] COST_WAIT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk,
    input  logic              cwai,
    input  logic              sync,
    input  src_e              src,
    input  logic              any_line,
    output logic              take,
    output logic [ADDR_W-1:0] vector,
    output logic              full_frame,
    output logic              push_frame,
    output logic              set_f,
    output logic              set_i,
    output logic [COST_W-1:0] cost,
    output logic              hold,
    output logic              wait_clr
);
    logic   go;
    entry_t ent;

    assign ent = entry_of(src);

    always_comb begin
        go = 1'b0;
        hold = 1'b0;
        wait_clr = 1'b0;
        cost = '0;
        if (rst) begin
            wait_clr = 1'b1;
        end else if (chk) begin
            if (cwai) begin
                if (src == SRC_NONE) begin
                    hold = 1'b1;
                    cost = COST_WAIT;
                end else begin
                    go = 1'b1;
                    wait_clr = 1'b1;
                end
            end else if (sync) begin
                if (!any_line) begin
                    hold = 1'b1;
                    cost = COST_WAIT;
                end else begin
                    wait_clr = 1'b1;
                    go = (src != SRC_NONE);
                end
            end else begin
                go = (src != SRC_NONE);
            end
        end

        take       = go;
        push_frame = go & ~cwai;
        full_frame = go & ent.full;
        set_f      = rst | (go & ent.set_f);
        set_i      = rst | (go & ent.set_i);
        vector     = VEC_RESET;
        if (go) begin
            case (src)
                SRC_NMI:  begin vector = VEC_NMI;  cost = COST_FULL;  end
                SRC_FIRQ: begin vector = VEC_FIRQ; cost = COST_SHORT; end
                SRC_IRQ:  begin vector = VEC_IRQ;  cost = COST_FULL;  end
                default:  begin vector = VEC_RESET; end
            endcase
        end
    end

    // R9 / R10: a held wait costs one cycle and enters nothing
    p_hold_cost_r9: assert property (@(posedge clk) disable iff (rst)
        hold |-> (cost == COST_WAIT && !take));

    // R7: the fast source always uses a short frame
    p_short_frame_r7: assert property (@(posedge clk) disable iff (rst)
        (take && src == SRC_FIRQ) |-> !full_frame);

    // R9: no second push out of a state-saving wait
    p_cwai_nopush_r9: assert property (@(posedge clk) disable iff (rst)
        (take && cwai) |-> !push_frame);

    // R1: nothing happens between boundaries
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !chk |-> (!take && !hold));

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import irq_arb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int COST_W = 5,
    parameter logic [ADDR_W-1:0] VEC_RESET = DEF_VEC_RESET,
    parameter logic [ADDR_W-1:0] VEC_NMI   = DEF_VEC_NMI,
    parameter logic [ADDR_W-1:0] VEC_FIRQ  = DEF_VEC_FIRQ,
    parameter logic [ADDR_W-1:0] VEC_IRQ   = DEF_VEC_IRQ,
    parameter logic [COST_W-1:0] COST_FULL  = 19,
    parameter logic [COST_W-1:0] COST_SHORT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk,
    input  logic              nmi_req,
    input  logic              firq_req,
    input  logic              irq_req,
    input  logic              firq_mask,
    input  logic              irq_mask,
    input  logic              sp_wr,
    input  logic              wait_cwai,
    input  logic              wait_sync,
    output logic              take,
    output logic [ADDR_W-1:0] vector,
    output logic              full_frame,
    output logic              push_frame,
    output logic              set_firq_msk,
    output logic              set_irq_msk,
    output logic [COST_W-1:0] cost,
    output logic              hold,
    output logic              wait_clr
);
    logic nmi_pend;
    logic any_line;
    logic nmi_served;
    src_e src;

    assign nmi_served = take & (src == SRC_NMI);

    arb_nmi_latch u_nmi (
        .clk      (clk),
        .rst      (rst),
        .nmi_line (nmi_req),
        .sp_wr    (sp_wr),
        .serviced (nmi_served),
        .pending  (nmi_pend)
    );

    arb_select u_sel (
        .nmi_pend  (nmi_pend),
        .firq_req  (firq_req),
        .irq_req   (irq_req),
        .firq_mask (firq_mask),
        .irq_mask  (irq_mask),
        .src       (src),
        .any_line  (any_line)
    );

    arb_waitgate #(
        .ADDR_W     (ADDR_W),
        .COST_W     (COST_W),
        .VEC_RESET  (VEC_RESET),
        .VEC_NMI    (VEC_NMI),
        .VEC_FIRQ   (VEC_FIRQ),
        .VEC_IRQ    (VEC_IRQ),
        .COST_FULL  (COST_FULL),
        .COST_SHORT (COST_SHORT),
        .COST_WAIT  (1)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .chk        (chk),
        .cwai       (wait_cwai),
        .sync       (wait_sync),
        .src        (src),
        .any_line   (any_line),
        .take       (take),
        .vector     (vector),
        .full_frame (full_frame),
        .push_frame (push_frame),
        .set_f      (set_firq_msk),
        .set_i      (set_irq_msk),
        .cost       (cost),
        .hold       (hold),
        .wait_clr   (wait_clr)
    );

    // R1: a pending non-maskable request beats any maskable one
    p_nmi_first_r1: assert property (@(posedge clk) disable iff (rst)
        (take && nmi_pend) |-> (vector == VEC_NMI));

    // R2: an inhibited fast request is never entered
    p_masked_firq_r2: assert property (@(posedge clk) disable iff (rst)
        (take && firq_mask) |-> (vector != VEC_FIRQ));

    // R6: the normal source never sets the fast inhibit
    p_irq_masks_r6: assert property (@(posedge clk) disable iff (rst)
        (take && vector == VEC_IRQ) |-> (set_irq_msk && !set_firq_msk));

endmodule

// File: tb/exc_arbiter_tb_top.sv
module exc_arbiter_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chk = 1'b0;
    logic nmi_req = 1'b0, firq_req = 1'b0, irq_req = 1'b0;
    logic firq_mask = 1'b1, irq_mask = 1'b1;
    logic sp_wr = 1'b0, wait_cwai = 1'b0, wait_sync = 1'b0;

    logic        take, full_frame, push_frame, set_firq_msk, set_irq_msk, hold, wait_clr;
    logic [15:0] vector;
    logic [4:0]  cost;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R11";

    // behavioural model state
    bit m_armed = 0, m_pend = 0, m_prev = 0;
    bit e_take, e_full, e_push, e_sf, e_si, e_hold, e_clr;
    int e_vec, e_cost;
    bit e_nmi_taken;

    always #5 clk = ~clk;

    exc_arbiter dut_i (
        .clk(clk), .rst(rst), .chk(chk),
        .nmi_req(nmi_req), .firq_req(firq_req), .irq_req(irq_req),
        .firq_mask(firq_mask), .irq_mask(irq_mask), .sp_wr(sp_wr),
        .wait_cwai(wait_cwai), .wait_sync(wait_sync),
        .take(take), .vector(vector), .full_frame(full_frame),
        .push_frame(push_frame), .set_firq_msk(set_firq_msk),
        .set_irq_msk(set_irq_msk), .cost(cost), .hold(hold), .wait_clr(wait_clr)
    );

    task automatic cmp(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic predict();
        string who;
        bit fok, iok, go;
        e_take = 0; e_full = 0; e_push = 0; e_sf = 0; e_si = 0;
        e_hold = 0; e_clr = 0; e_vec = 'hFFFE; e_cost = 0; e_nmi_taken = 0;
        who = "none";
        fok = firq_req && !firq_mask;
        iok = irq_req && !irq_mask;
        if (m_pend) who = "nmi";
        else if (fok) who = "firq";
        else if (iok) who = "irq";
        go = 0;
        if (rst) begin
            e_sf = 1; e_si = 1; e_clr = 1;
        end else if (chk) begin
            if (wait_cwai) begin
                if (who == "none") begin e_hold = 1; e_cost = 1; end
                else begin go = 1; e_clr = 1; end
            end else if (wait_sync) begin
                if (!(m_pend || firq_req || irq_req)) begin e_hold = 1; e_cost = 1; end
                else begin e_clr = 1; go = (who != "none"); end
            end else go = (who != "none");
        end
        if (go) begin
            e_take = 1;
            e_push = !wait_cwai;
            if (who == "nmi") begin
                e_vec = 'hFFFC; e_cost = 19; e_full = 1; e_sf = 1; e_si = 1; e_nmi_taken = 1;
            end else if (who == "firq") begin
                e_vec = 'hFFF6; e_cost = 10; e_full = 0; e_sf = 1; e_si = 1;
            end else begin
                e_vec = 'hFFF8; e_cost = 19; e_full = 1; e_si = 1;
            end
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        predict();
        cmp("take", take, e_take);
        cmp("vector", vector, e_vec);
        cmp("full_frame", full_frame, e_full);
        cmp("push_frame", push_frame, e_push);
        cmp("set_firq_msk", set_firq_msk, e_sf);
        cmp("set_irq_msk", set_irq_msk, e_si);
        cmp("cost", cost, e_cost);
        cmp("hold", hold, e_hold);
        cmp("wait_clr", wait_clr, e_clr);
        @(posedge clk);
        #1;
        if (rst) begin
            m_armed = 0; m_pend = 0; m_prev = 0;
        end else begin
            m_pend  = (m_pend && !e_nmi_taken) || (m_armed && nmi_req && !m_prev);
            m_armed = m_armed || sp_wr;
            m_prev  = nmi_req;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        // R11: reset outputs
        cur_req = "R11";
        rst = 1; chk = 1; irq_req = 1; irq_mask = 0;
        idle(3);
        rst = 0; chk = 0; irq_req = 0; irq_mask = 1;

        // R1: idle between boundaries, R5: idle vector
        cur_req = "R1";
        firq_req = 1; firq_mask = 0;
        idle(2);
        cur_req = "R5";
        firq_req = 0; chk = 1;
        idle(1);

        // R2: normal request level-taken when unmasked, ignored when masked
        cur_req = "R2";
        irq_req = 1; irq_mask = 1; idle(2);
        irq_mask = 0; idle(2);
        // R6 / R7 / R8 on the normal source
        cur_req = "R6"; idle(1);

        // R1: fast beats normal; R7 short frame; R8 cost 10
        cur_req = "R1";
        firq_req = 1; firq_mask = 0; idle(1);
        cur_req = "R7"; idle(1);
        cur_req = "R8"; firq_mask = 1; idle(1);
        irq_req = 0; firq_req = 0;

        // R4: edges before arming are discarded
        cur_req = "R4";
        chk = 0; nmi_req = 1; idle(1); nmi_req = 0; idle(1);
        chk = 1; idle(2);
        sp_wr = 1; idle(1); sp_wr = 0;

        // R3: edge latched with no check, held, taken once
        cur_req = "R3";
        chk = 0; nmi_req = 1; idle(4);
        firq_req = 1; firq_mask = 0; irq_req = 1; irq_mask = 0;
        chk = 1; idle(1);            // non-maskable wins (R1)
        idle(2);                     // line still high: no retrigger
        nmi_req = 0; firq_req = 0; irq_req = 0; idle(1);
        // R5 vector seen under priority
        cur_req = "R5";
        nmi_req = 1; chk = 0; idle(1); chk = 1; idle(1); nmi_req = 0;

        // R9: state-saving wait
        cur_req = "R9";
        wait_cwai = 1; irq_mask = 1; firq_mask = 1;
        irq_req = 1; firq_req = 1; idle(3);
        irq_mask = 0; idle(1);
        wait_cwai = 0; irq_req = 0; firq_req = 0;

        // R10: synchronisation wait
        cur_req = "R10";
        wait_sync = 1; idle(3);
        irq_req = 1; irq_mask = 1; idle(1);
        irq_mask = 0; idle(1);
        firq_req = 1; firq_mask = 1; irq_req = 0; idle(1);
        wait_sync = 0; firq_req = 0;

        // R4: reset disarms and drops pending
        cur_req = "R4";
        chk = 0; nmi_req = 1; idle(1);
        rst = 1; idle(2); rst = 0; nmi_req = 0; idle(1);
        nmi_req = 1; chk = 1; idle(3); nmi_req = 0;

        // random mix
        cur_req = "R1";
        for (int i = 0; i < 400; i++) begin
            chk       = $urandom_range(0, 2) != 0;
            nmi_req   = $urandom_range(0, 3) == 0;
            firq_req  = $urandom_range(0, 2) == 0;
            irq_req   = $urandom_range(0, 1) == 0;
            firq_mask = $urandom_range(0, 1) == 0;
            irq_mask  = $urandom_range(0, 1) == 0;
            sp_wr     = $urandom_range(0, 30) == 0;
            wait_cwai = $urandom_range(0, 4) == 0;
            wait_sync = !wait_cwai && ($urandom_range(0, 4) == 0);
            rst       = $urandom_range(0, 60) == 0;
            idle(1);
        end
        rst = 0;

        summary();
        $finish;
    end

endmodule